// File: doc/BRIEF.md
# SPI Master with Selectable Chip-Select Policy

This block is a serial peripheral interface master. It moves frames of 1 to `MAX_BITS` bits, most significant bit first, to and from one of `NUM_SLV` slaves. Each slave has its own select line, and each line has its own programmable active level. Frames enter on a valid/ready port. A `tx_last` flag marks the final frame of a transaction. One frame of received data comes back on `rx_valid`/`rx_data` for every frame sent, in the order they were sent.

Two select policies are offered. In per-frame mode (`cfg_held` = 0) every frame is a transaction of its own: the select goes active, the frame shifts, and the select is released. The line then stays inactive for at least one serial clock period before the next frame. In held mode (`cfg_held` = 1) the select goes active once and stays active across every frame up to the one flagged last. This serves slaves that reset their serial logic whenever their select is dropped. A keep flag on the last frame can leave the select active into the following transaction. The clock polarity and phase cover all four SPI modes. The serial clock period is `2*cfg_half` system cycles. A programmable lead delay sits between select assertion and the first clock edge, and a trail delay of the same length sits between the last clock edge and the release.

The controller has seven states:
- `ST_IDLE` goes to `ST_LEAD` when a frame is accepted.
- `ST_LEAD` goes to `ST_SHIFT` when the delay expires.
- `ST_SHIFT` goes to `ST_HOLD` when a non-last frame ends in held mode, and to `ST_TRAIL` otherwise.
- `ST_HOLD` goes to `ST_SHIFT` when the next frame is accepted.
- `ST_TRAIL` goes to `ST_KEEP` in held mode with keep set, and to `ST_GAP` otherwise.
- `ST_GAP` goes to `ST_IDLE` after one serial period.
- `ST_KEEP` goes to `ST_SHIFT` when a frame is accepted.

Top module: `spi_cs_master`

## Requirements
- R1: The frame length is `cfg_bits` bits (1 to `MAX_BITS`; 8, 12 and 16 are used). Data is taken from the low `cfg_bits` bits of `tx_data` and sent most significant bit first on `mosi`.
- R2: With `cfg_cpha` = 0, `mosi` is valid before the leading clock edge and `miso` is sampled on that edge. With `cfg_cpha` = 1, `miso` is sampled on the trailing edge. The leading edge is the one that moves the clock away from its idle level.
- R3: `sclk` rests at `cfg_cpol` whenever `busy` is low. During a frame, its edges are spaced exactly `cfg_half` system cycles apart (`cfg_half` >= 1).
- R4: In held mode, the select stays active from the first frame to the frame flagged `tx_last`, and is released exactly once per transaction.
- R5: In per-frame mode, the select is released after every frame and stays inactive for at least `2*cfg_half` cycles before the next frame. `tx_last` has no effect in this mode.
- R6: A select output is at level `cfg_act_hi[i]` when active and at the inverse when inactive, and at most one select is active at any time.
- R7: `rx_valid` pulses once per frame. `rx_data` then holds the `cfg_bits` bits sampled from `miso`, right-aligned, with the first bit sampled in the most significant position.
- R8: At least `cfg_dly` system cycles pass between select assertion and the first clock edge, and between the last clock edge and the select release.
- R9: In held mode, a last frame sent with `tx_keep` = 1 leaves the select active and `busy` high. The next accepted frame shifts on the same slave without a release, and its `tx_slave` value is ignored.
- R10: `busy` is high from each select assertion until the matching release, and falls once per release.
- R11: `tx_ready` is high only in idle, between held frames, and while a kept select waits. It is low during the lead delay, the shift, the trail delay and the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_bits | input | BIT_W | Frame length in bits |
| cfg_half | input | DIV_W | Half serial period in system cycles (>= 1) |
| cfg_dly | input | DLY_W | Lead and trail delay in system cycles |
| cfg_held | input | 1 | 1: select held across a transaction; 0: per-frame select |
| cfg_act_hi | input | NUM_SLV | Per-slave active level of the select (1 = active high) |
| tx_valid | input | 1 | Frame offered |
| tx_ready | output | 1 | Frame accepted when high together with tx_valid |
| tx_data | input | MAX_BITS | Frame to send, right-aligned |
| tx_slave | input | IDX_W | Slave index, taken at the start of a transaction |
| tx_last | input | 1 | Final frame of a held transaction |
| tx_keep | input | 1 | With tx_last in held mode: keep the select active afterwards |
| rx_valid | output | 1 | One-cycle pulse per completed frame |
| rx_data | output | MAX_BITS | Received frame, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | NUM_SLV | Per-slave select lines |
| busy | output | 1 | A select is active |

## Verification
The assertions assume the following about the inputs:
- The configuration inputs (`cfg_*`) stay constant while `busy` is high.
- `cfg_half` is never zero.
- The slave model in the bench changes `miso` only on the half cycle after the clock edge that shifts it.

The bench writes the configuration only after it has waited for `busy` to fall and the gap to pass. It always uses `cfg_half` values of 1 to 3. It offers frames only at falling system-clock edges and holds them until `tx_ready` has been seen.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_HOLD,
        ST_TRAIL,
        ST_GAP,
        ST_KEEP
    } sel_state_t;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (half != '0)); // R3
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
    parameter int MAX_BITS = 16,
    parameter int BIT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] ld_word,
    input  logic                edge_i,
    input  logic                cpol,
    input  logic                cpha,
    input  logic [BIT_W-1:0]    bits,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_word
);
    localparam int EC_W = BIT_W + 1;

    logic [MAX_BITS-1:0] tx_sr, rx_sr;
    logic [EC_W-1:0]     ecnt, lastc;
    logic [BIT_W-1:0]    sh;
    logic                ph;

    assign sh      = BIT_W'(MAX_BITS) - bits;
    assign lastc   = {bits, 1'b0} - EC_W'(1);
    assign done    = edge_i && (ecnt == lastc);
    assign sclk    = cpol ^ ph;
    assign mosi    = tx_sr[MAX_BITS-1];
    assign rx_word = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            ecnt  <= '0;
            ph    <= 1'b0;
        end else if (load) begin
            tx_sr <= ld_word << sh;
            rx_sr <= '0;
            ecnt  <= '0;
            ph    <= 1'b0;
        end else if (edge_i) begin
            ph   <= ~ph;
            ecnt <= (ecnt == lastc) ? '0 : ecnt + EC_W'(1);
            if (!ecnt[0]) begin
                if (!cpha)
                    rx_sr <= {rx_sr[MAX_BITS-2:0], miso};
                else if (ecnt != '0)
                    tx_sr <= tx_sr << 1;
            end else begin
                if (cpha)
                    rx_sr <= {rx_sr[MAX_BITS-2:0], miso};
                else
                    tx_sr <= tx_sr << 1;
            end
        end
    end

    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt <= lastc); // R1
    AST_PHASE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ph); // R3
endmodule

// File: rtl/spi_sel_drv.sv
module spi_sel_drv #(
    parameter int NUM_SLV = 4,
    parameter int IDX_W   = 2
) (
    input  logic               on,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SLV-1:0] pol,
    output logic [NUM_SLV-1:0] cs
);
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_sel
        assign cs[i] = (on && (idx == IDX_W'(i))) ? pol[i] : ~pol[i];
    end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter  int NUM_SLV  = 4,
    parameter  int MAX_BITS = 16,
    parameter  int DIV_W    = 8,
    parameter  int DLY_W    = 8,
    localparam int IDX_W    = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1,
    localparam int BIT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic [BIT_W-1:0]    cfg_bits,
    input  logic [DIV_W-1:0]    cfg_half,
    input  logic [DLY_W-1:0]    cfg_dly,
    input  logic                cfg_held,
    input  logic [NUM_SLV-1:0]  cfg_act_hi,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic [IDX_W-1:0]    tx_slave,
    input  logic                tx_last,
    input  logic                tx_keep,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_SLV-1:0]  cs,
    output logic                busy
);
    localparam int CNT_W = ((DLY_W > DIV_W + 1) ? DLY_W : DIV_W + 1) + 1;

    sel_state_t       state, state_nxt;
    logic [CNT_W-1:0] dcnt;
    logic [IDX_W-1:0] slv_q;
    logic             last_q, keep_q;
    logic             accept, run, tick, frame_done, dly_hit, gap_hit;

    assign accept  = tx_valid && tx_ready;
    assign dly_hit = dcnt >= CNT_W'(cfg_dly);
    assign gap_hit = dcnt >= CNT_W'({cfg_half, 1'b0});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (accept)  state_nxt = ST_LEAD;
            ST_LEAD:  if (dly_hit) state_nxt = ST_SHIFT;
            ST_SHIFT: if (frame_done)
                          state_nxt = (cfg_held && !last_q) ? ST_HOLD : ST_TRAIL;
            ST_HOLD:  if (accept)  state_nxt = ST_SHIFT;
            ST_TRAIL: if (dly_hit)
                          state_nxt = (cfg_held && keep_q) ? ST_KEEP : ST_GAP;
            ST_GAP:   if (gap_hit) state_nxt = ST_IDLE;
            ST_KEEP:  if (accept)  state_nxt = ST_SHIFT;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        tx_ready = 1'b0;
        busy     = 1'b0;
        run      = 1'b0;
        unique case (state)
            ST_IDLE:  tx_ready = 1'b1;
            ST_LEAD:  busy = 1'b1;
            ST_SHIFT: begin busy = 1'b1; run = 1'b1; end
            ST_HOLD:  begin busy = 1'b1; tx_ready = 1'b1; end
            ST_TRAIL: busy = 1'b1;
            ST_GAP:   ;
            ST_KEEP:  begin busy = 1'b1; tx_ready = 1'b1; end
            default:  ;
        endcase
    end

    // delay counter and transaction attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt     <= '0;
            slv_q    <= '0;
            last_q   <= 1'b0;
            keep_q   <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= frame_done;
            if (state_nxt != state)
                dcnt <= '0;
            else if (state == ST_LEAD || state == ST_TRAIL || state == ST_GAP)
                dcnt <= dcnt + CNT_W'(1);
            if (accept) begin
                last_q <= tx_last;
                keep_q <= tx_keep;
                if (state == ST_IDLE)
                    slv_q <= tx_slave;
            end
        end
    end

    spi_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(run), .half(cfg_half), .tick(tick)
    );

    spi_shift_eng #(.MAX_BITS(MAX_BITS), .BIT_W(BIT_W)) shf_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .ld_word(tx_data),
        .edge_i(tick), .cpol(cfg_cpol), .cpha(cfg_cpha), .bits(cfg_bits),
        .miso(miso), .sclk(sclk), .mosi(mosi), .done(frame_done),
        .rx_word(rx_data)
    );

    spi_sel_drv #(.NUM_SLV(NUM_SLV), .IDX_W(IDX_W)) sel_i (
        .on(busy), .idx(slv_q), .pol(cfg_act_hi), .cs(cs)
    );

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(cs ^ cfg_act_hi))); // R6
    AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg_cpol)); // R3
    AST_RX_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state == ST_SHIFT)); // R7
    AST_HOLD_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> busy); // R4
    AST_GAP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (cs == ~cfg_act_hi)); // R5
    AST_KEEP_NO_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KEEP && tx_valid) |=> (state == ST_SHIFT)); // R9
endmodule

// File: tb/spi_cs_master_tb_top.sv
module spi_cs_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int MB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_held = 1'b0;
    logic [4:0]    cfg_bits = 5'd8;
    logic [7:0]    cfg_half = 8'd2, cfg_dly = 8'd0;
    logic [NS-1:0] cfg_act_hi = 4'b0110;
    logic          tx_valid = 1'b0, tx_last = 1'b0, tx_keep = 1'b0;
    logic [MB-1:0] tx_data = '0;
    logic [1:0]    tx_slave = '0;
    logic          tx_ready, rx_valid, sclk, mosi, busy;
    logic [MB-1:0] rx_data;
    logic [NS-1:0] cs;
    logic          miso_r = 1'b0;
    logic          mon_clr = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cs_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_bits(cfg_bits), .cfg_half(cfg_half), .cfg_dly(cfg_dly),
        .cfg_held(cfg_held), .cfg_act_hi(cfg_act_hi), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_slave(tx_slave),
        .tx_last(tx_last), .tx_keep(tx_keep), .rx_valid(rx_valid),
        .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso_r),
        .cs(cs), .busy(busy)
    );

    function automatic logic [15:0] resp(int i);
        return 16'h9C35 ^ 16'(i * 16'h2B17);
    endfunction

    function automatic logic [15:0] mask(logic [15:0] w);
        return w & 16'((32'd1 << cfg_bits) - 1);
    endfunction

    // slave model and bus monitor
    int e_cnt, fidx, cyc_act, cyc_edge, cyc_off, min_lead, min_trail, min_gap;
    int hp_min, hp_max, rel_cnt, busy_fall, mo_n, rx_n;
    logic [15:0] mo_acc;
    logic [15:0] mo_log [16];
    logic [15:0] rx_log [16];
    logic sclk_q, act_q, busy_q, seen_rel, lead_pend;
    logic [NS-1:0] act_seen;

    always @(negedge clk) begin
        logic [NS-1:0] act;
        logic          any, lead;
        logic [15:0]   w;
        int            k;
        act = ~(cs ^ cfg_act_hi);
        any = |act;
        if (mon_clr) begin
            e_cnt = 0; fidx = 0; cyc_act = 0; cyc_edge = 0; cyc_off = 0;
            min_lead = 1000000; min_trail = 1000000; min_gap = 1000000;
            hp_min = 1000000; hp_max = 0; rel_cnt = 0; busy_fall = 0;
            mo_n = 0; rx_n = 0; mo_acc = '0; act_seen = '0;
            seen_rel = 0; lead_pend = 0;
        end else begin
            cyc_act++; cyc_edge++; cyc_off++;
            act_seen = act_seen | act;
            if (any && !act_q) begin
                if (seen_rel && cyc_off < min_gap) min_gap = cyc_off;
                cyc_act = 0;
                lead_pend = 1;
            end
            if (!any && act_q) begin
                rel_cnt++;
                seen_rel = 1;
                cyc_off = 0;
                if (cyc_edge < min_trail) min_trail = cyc_edge;
            end
            if (busy_q && !busy) busy_fall++;
            if (sclk != sclk_q) begin
                lead = (sclk != cfg_cpol);
                if (lead_pend) begin
                    if (cyc_act < min_lead) min_lead = cyc_act;
                    lead_pend = 0;
                end
                if (e_cnt > 0) begin
                    if (cyc_edge < hp_min) hp_min = cyc_edge;
                    if (cyc_edge > hp_max) hp_max = cyc_edge;
                end
                cyc_edge = 0;
                if (lead != cfg_cpha) mo_acc = {mo_acc[14:0], mosi};
                e_cnt++;
                if (e_cnt == 2 * int'(cfg_bits)) begin
                    if (mo_n < 16) mo_log[mo_n] = mask(mo_acc);
                    mo_n++;
                    e_cnt = 0;
                    fidx++;
                end
            end
            if (rx_valid) begin
                if (rx_n < 16) rx_log[rx_n] = rx_data;
                rx_n++;
            end
        end
        k = cfg_cpha ? ((e_cnt == 0) ? 0 : (e_cnt - 1) / 2) : e_cnt / 2;
        w = resp(fidx);
        miso_r = w[int'(cfg_bits) - 1 - k];
        sclk_q = sclk; act_q = any; busy_q = busy;
    end

    task automatic chk(bit ok, string req, int actual, int expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic clr_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic send(logic [15:0] d, int s, bit last, bit keep);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = d; tx_slave = 2'(s);
        tx_last = last; tx_keep = keep;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2 * int'(cfg_half) + 6) @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(cs == ~cfg_act_hi, "R6 reset select levels", cs, ~cfg_act_hi);
        chk(sclk == cfg_cpol, "R3 reset clock idle", sclk, cfg_cpol);
        chk(busy == 1'b0, "R10 reset busy", busy, 0);
        chk(tx_ready == 1'b1, "R11 reset ready", tx_ready, 1);
        chk(rx_valid == 1'b0, "R7 reset rx_valid", rx_valid, 0);
    endtask

    // mode 0, per-frame, 8-bit, slave 0 active-low
    task automatic test_per_frame_m0();
        logic [15:0] f [3];
        f[0] = 16'h3C; f[1] = 16'hA1; f[2] = 16'h7E;
        cfg_cpol = 0; cfg_cpha = 0; cfg_bits = 8; cfg_half = 2; cfg_dly = 3; cfg_held = 0;
        clr_mon();
        send(f[0], 0, 0, 0);
        send(f[1], 0, 1, 0);
        send(f[2], 0, 0, 0);
        wait_idle();
        chk(mo_n == 3, "R1 frames seen", mo_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk(mo_log[i] == f[i], "R1 R2 mosi word mode0", mo_log[i], f[i]);
            chk(rx_log[i] == mask(resp(i)), "R7 rx word mode0", rx_log[i], mask(resp(i)));
        end
        chk(rx_n == 3, "R7 rx count", rx_n, 3);
        chk(rel_cnt == 3, "R5 release per frame", rel_cnt, 3);
        chk(min_gap >= 4, "R5 gap length", min_gap, 4);
        chk(hp_min == 2 && hp_max == 2, "R3 half period", hp_max, 2);
        chk(min_lead >= 3, "R8 lead delay", min_lead, 3);
        chk(min_trail >= 3, "R8 trail delay", min_trail, 3);
        chk(act_seen == 4'b0001, "R6 only slave 0", act_seen, 4'b0001);
        chk(busy_fall == 3, "R10 busy falls", busy_fall, 3);
    endtask

    // mode 3, held, 16-bit, slave 2 active-high
    task automatic test_held_m3();
        logic [15:0] f [3];
        f[0] = 16'hBEEF; f[1] = 16'h1234; f[2] = 16'h8001;
        cfg_cpol = 1; cfg_cpha = 1; cfg_bits = 16; cfg_half = 3; cfg_dly = 1; cfg_held = 1;
        clr_mon();
        send(f[0], 2, 0, 0);
        send(f[1], 2, 0, 0);
        send(f[2], 2, 1, 0);
        wait_idle();
        for (int i = 0; i < 3; i++) begin
            chk(mo_log[i] == f[i], "R1 R2 mosi word mode3", mo_log[i], f[i]);
            chk(rx_log[i] == resp(i), "R7 rx word mode3", rx_log[i], resp(i));
        end
        chk(rel_cnt == 1, "R4 single release", rel_cnt, 1);
        chk(busy_fall == 1, "R10 single busy fall", busy_fall, 1);
        chk(hp_min == 3 && hp_max == 3, "R3 half period held", hp_max, 3);
        chk(min_lead >= 1, "R8 lead delay held", min_lead, 1);
        chk(act_seen == 4'b0100, "R6 only slave 2", act_seen, 4'b0100);
        chk(sclk == 1'b1, "R3 idle high", sclk, 1);
    endtask

    // mode 1, held with keep, slave 1 active-high
    task automatic test_keep_m1();
        cfg_cpol = 0; cfg_cpha = 1; cfg_bits = 8; cfg_half = 1; cfg_dly = 2; cfg_held = 1;
        clr_mon();
        send(16'h5A, 1, 0, 0);
        chk(tx_ready == 1'b0, "R11 not ready while selecting", tx_ready, 0);
        send(16'hC3, 1, 1, 1);
        repeat (30) @(negedge clk);
        chk(cs[1] == 1'b1 && busy == 1'b1, "R9 select kept", {busy, cs[1]}, 3);
        chk(rel_cnt == 0, "R9 no release yet", rel_cnt, 0);
        send(16'h0F, 3, 1, 0);
        wait_idle();
        chk(rel_cnt == 1, "R9 one release", rel_cnt, 1);
        chk(act_seen == 4'b0010, "R9 slave index ignored", act_seen, 4'b0010);
        chk(mo_n == 3 && mo_log[2] == 16'h0F, "R9 kept frame shifted", mo_log[2], 16'h0F);
        chk(rx_n == 3 && rx_log[2] == mask(resp(2)), "R7 rx after keep", rx_log[2], mask(resp(2)));
        chk(mo_log[0] == 16'h5A && mo_log[1] == 16'hC3, "R2 mosi mode1", mo_log[1], 16'hC3);
    endtask

    // mode 2, per-frame, 12-bit, slave 3 active-low
    task automatic test_per_frame_m2();
        cfg_cpol = 1; cfg_cpha = 0; cfg_bits = 12; cfg_half = 2; cfg_dly = 0; cfg_held = 0;
        clr_mon();
        send(16'hABC, 3, 1, 0);
        send(16'h123, 3, 0, 0);
        wait_idle();
        chk(mo_log[0] == 16'hABC && mo_log[1] == 16'h123, "R1 12-bit frames", mo_log[1], 16'h123);
        chk(rx_log[0] == mask(resp(0)) && rx_log[1] == mask(resp(1)), "R7 rx mode2", rx_log[1], mask(resp(1)));
        chk(rel_cnt == 2, "R5 release per frame mode2", rel_cnt, 2);
        chk(act_seen == 4'b1000, "R6 only slave 3", act_seen, 4'b1000);
        chk(cs == ~cfg_act_hi, "R6 all inactive after", cs, ~cfg_act_hi);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_per_frame_m0();
        test_held_m3();
        test_keep_m1();
        test_per_frame_m2();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule